// File: doc/BRIEF.md
# ECC Error Event Reporting Unit

This unit sits beside a RAM array and a flash array and collects the error events that their ECC logic raises. Each array can signal two kinds of event: a single-bit error that was corrected, or an error that could not be corrected. Each of the four event kinds has its own software enable. An event that is enabled records a status flag for its kind. In the same cycle it captures the address and access attributes that came with it, so the flag and the captured data always describe the same event.

Only one status flag is ever set. A newer enabled event replaces the pending flag and the captured data. Software reads the flag and the capture registers through a small register port and clears the flag by writing a one to it. The unit drives five interrupt requests from the flags and the enables: RAM-uncorrectable, flash-uncorrectable, any single-bit, any uncorrectable, and an overall request.

Top module: `ecc_evt_report`

## Requirements
- R1: After reset the enable, status, captured address and captured attribute registers all read zero, and every interrupt output is low.
- R2: An event whose kind is disabled changes neither the status register nor the capture registers.
- R3: An enabled event sets its own status bit (bit 0 RAM single-bit, bit 1 flash single-bit, bit 2 RAM uncorrectable, bit 3 flash uncorrectable). The captured address and attribute come from the array that raised the event, and all of this is readable from the cycle after the event.
- R4: At most one status bit is set at any time.
- R5: An enabled event that arrives while a flag is pending clears that flag and replaces the captured address and attribute.
- R6: When several enabled events arrive in the same cycle, one of them is recorded, in this order of precedence: RAM uncorrectable, flash uncorrectable, RAM single-bit, flash single-bit.
- R7: Writing to the status register (offset 1) clears each status bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R8: If an enabled event and a status write arrive in the same cycle, the event is recorded and its flag stays set, even if the write clears that same bit.
- R9: Each interrupt is computed from the registers, with pending meaning status AND enable. irqSingle is pending bit 0 OR pending bit 1. irqRamUncorr is pending bit 2. irqFlashUncorr is pending bit 3. irqUncorr is irqRamUncorr OR irqFlashUncorr. irqAny is irqSingle OR irqUncorr.
- R10: The register offsets are: 0 enable (same bit layout as status, read/write), 1 status, 2 captured address (read-only), 3 captured attribute (read-only). The bits above bit 3 of the enable and status registers read zero, unmapped offsets read zero, and writes to the capture registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ramCorrPulse | input | 1 | RAM single-bit corrected event |
| flashCorrPulse | input | 1 | Flash single-bit corrected event |
| ramUncorrPulse | input | 1 | RAM uncorrectable event |
| flashUncorrPulse | input | 1 | Flash uncorrectable event |
| ramAddr | input | ADDR_W | Address of the RAM access |
| ramAttr | input | ATTR_W | Attributes of the RAM access |
| flashAddr | input | ADDR_W | Address of the flash access |
| flashAttr | input | ATTR_W | Attributes of the flash access |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register offset for reads and writes |
| regWrData | input | 4 | Register write data |
| regRdData | output | RD_W | Combinational read data for regAddr |
| irqSingle | output | 1 | Single-bit interrupt request |
| irqRamUncorr | output | 1 | RAM uncorrectable interrupt request |
| irqFlashUncorr | output | 1 | Flash uncorrectable interrupt request |
| irqUncorr | output | 1 | Combined uncorrectable interrupt request |
| irqAny | output | 1 | Overall interrupt request |

## Verification
The hardest situations to reach from the ports are cycles where several things collide. One is simultaneous events from both arrays. Another is an event that lands in the same cycle as a write-one-to-clear aimed at the very bit it sets. The bench drives these on purpose in directed steps: all four pulses together with distinct RAM and flash addresses, a clear of the pending flag paired with a fresh event, and a clear paired with a repeat of the same event kind. A long phase follows with random pulses, enable rewrites and status writes, checked cycle by cycle against a behavioural model. Together these reach the mixes of enabled and disabled kinds that directed steps would miss.

// File: rtl/ecc_evt_pkg.sv
package ecc_evt_pkg;

  localparam int NUM_EVT = 4;

  // status / enable bit positions, also the software-visible layout
  localparam int EVT_RAM_COR = 0;
  localparam int EVT_FLS_COR = 1;
  localparam int EVT_RAM_UNC = 2;
  localparam int EVT_FLS_UNC = 3;

  // register offsets
  localparam int OFF_EN   = 0;
  localparam int OFF_STS  = 1;
  localparam int OFF_ADDR = 2;
  localparam int OFF_ATTR = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic               load;
    logic [NUM_EVT-1:0] setMask;
    logic               fromFlash;
    logic               enWr;
    logic [NUM_EVT-1:0] clrMask;
  } ecc_strobe_t;

endpackage

// File: rtl/ecc_evt_ctrl.sv
module ecc_evt_ctrl
  import ecc_evt_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic [NUM_EVT-1:0] enReg,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [NUM_EVT-1:0] regWrData,
  output ecc_strobe_t        strobe
);

  // highest precedence first
  localparam int PRIO [NUM_EVT] = '{EVT_RAM_UNC, EVT_FLS_UNC, EVT_RAM_COR, EVT_FLS_COR};

  logic [NUM_EVT-1:0] liveEvt;
  logic [NUM_EVT-1:0] pick;
  logic               wrEnReg;
  logic               wrStsReg;

  assign liveEvt  = evtPulse & enReg;
  assign wrEnReg  = regWrEn && (regAddr == REG_AW'(OFF_EN));
  assign wrStsReg = regWrEn && (regAddr == REG_AW'(OFF_STS));

  // walk from lowest to highest precedence so the last hit wins
  always_comb begin
    pick = '0;
    for (int k = NUM_EVT - 1; k >= 0; k--) begin
      if (liveEvt[PRIO[k]]) begin
        pick          = '0;
        pick[PRIO[k]] = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load      = |liveEvt;
    strobe.setMask   = pick;
    strobe.fromFlash = pick[EVT_FLS_COR] | pick[EVT_FLS_UNC];
    strobe.enWr      = wrEnReg;
    strobe.clrMask   = wrStsReg ? regWrData : '0;
  end

endmodule

// File: rtl/ecc_evt_dpath.sv
module ecc_evt_dpath
  import ecc_evt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8,
  parameter int REG_AW = 3,
  parameter int RD_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ecc_strobe_t        strobe,
  input  logic [NUM_EVT-1:0] regWrData,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [ADDR_W-1:0]  ramAddr,
  input  logic [ATTR_W-1:0]  ramAttr,
  input  logic [ADDR_W-1:0]  flashAddr,
  input  logic [ATTR_W-1:0]  flashAttr,
  output logic [NUM_EVT-1:0] enReg,
  output logic [NUM_EVT-1:0] stsReg,
  output logic [RD_W-1:0]    regRdData,
  output logic               irqSingle,
  output logic               irqRamUncorr,
  output logic               irqFlashUncorr,
  output logic               irqUncorr,
  output logic               irqAny
);

  logic [ADDR_W-1:0]  capAddr;
  logic [ATTR_W-1:0]  capAttr;
  logic [NUM_EVT-1:0] pend;

  // one flop per status flag: load of a new event beats a clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_sts
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 stsReg[i] <= 1'b0;
      else if (strobe.load)      stsReg[i] <= strobe.setMask[i];
      else if (strobe.clrMask[i]) stsReg[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enReg <= '0;
    else if (strobe.enWr) enReg <= regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capAttr <= '0;
    end else if (strobe.load) begin
      capAddr <= strobe.fromFlash ? flashAddr : ramAddr;
      capAttr <= strobe.fromFlash ? flashAttr : ramAttr;
    end
  end

  assign pend           = stsReg & enReg;
  assign irqSingle      = pend[EVT_RAM_COR] | pend[EVT_FLS_COR];
  assign irqRamUncorr   = pend[EVT_RAM_UNC];
  assign irqFlashUncorr = pend[EVT_FLS_UNC];
  assign irqUncorr      = irqRamUncorr | irqFlashUncorr;
  assign irqAny         = |pend;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_AW'(OFF_EN):   regRdData = RD_W'(enReg);
      REG_AW'(OFF_STS):  regRdData = RD_W'(stsReg);
      REG_AW'(OFF_ADDR): regRdData = RD_W'(capAddr);
      REG_AW'(OFF_ATTR): regRdData = RD_W'(capAttr);
      default:           regRdData = '0;
    endcase
  end

endmodule

// File: rtl/ecc_evt_report.sv
module ecc_evt_report
  import ecc_evt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8,
  parameter int REG_AW = 3,
  parameter int RD_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ramCorrPulse,
  input  logic               flashCorrPulse,
  input  logic               ramUncorrPulse,
  input  logic               flashUncorrPulse,
  input  logic [ADDR_W-1:0]  ramAddr,
  input  logic [ATTR_W-1:0]  ramAttr,
  input  logic [ADDR_W-1:0]  flashAddr,
  input  logic [ATTR_W-1:0]  flashAttr,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [NUM_EVT-1:0] regWrData,
  output logic [RD_W-1:0]    regRdData,
  output logic               irqSingle,
  output logic               irqRamUncorr,
  output logic               irqFlashUncorr,
  output logic               irqUncorr,
  output logic               irqAny
);

  logic [NUM_EVT-1:0] evtPulse;
  logic [NUM_EVT-1:0] enReg;
  logic [NUM_EVT-1:0] stsReg;
  ecc_strobe_t        strobe;

  assign evtPulse = {flashUncorrPulse, ramUncorrPulse, flashCorrPulse, ramCorrPulse};

  ecc_evt_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .evtPulse  (evtPulse),
    .enReg     (enReg),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  ecc_evt_dpath #(
    .ADDR_W (ADDR_W),
    .ATTR_W (ATTR_W),
    .REG_AW (REG_AW),
    .RD_W   (RD_W)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .regWrData      (regWrData),
    .regAddr        (regAddr),
    .ramAddr        (ramAddr),
    .ramAttr        (ramAttr),
    .flashAddr      (flashAddr),
    .flashAttr      (flashAttr),
    .enReg          (enReg),
    .stsReg         (stsReg),
    .regRdData      (regRdData),
    .irqSingle      (irqSingle),
    .irqRamUncorr   (irqRamUncorr),
    .irqFlashUncorr (irqFlashUncorr),
    .irqUncorr      (irqUncorr),
    .irqAny         (irqAny)
  );

endmodule

// File: rtl/ecc_evt_report_chk.sv
module ecc_evt_report_chk
  import ecc_evt_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtPulse,
  input logic [NUM_EVT-1:0] enReg,
  input logic [NUM_EVT-1:0] stsReg,
  input logic               regWrEn,
  input logic [REG_AW-1:0]  regAddr,
  input logic [NUM_EVT-1:0] regWrData,
  input logic               irqSingle,
  input logic               irqRamUncorr,
  input logic               irqFlashUncorr,
  input logic               irqUncorr,
  input logic               irqAny
);

  logic anyLive;
  logic stsWrite;
  assign anyLive  = |(evtPulse & enReg);
  assign stsWrite = regWrEn && (regAddr == REG_AW'(OFF_STS));

  p_flag_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stsReg));

  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!anyLive && !stsWrite) |=> $stable(stsReg));

  p_top_prio_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse[EVT_RAM_UNC] && enReg[EVT_RAM_UNC]) |=> (stsReg == 4'b0100));

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    anyLive |=> (stsReg != '0));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stsWrite && !anyLive) |=> ((stsReg & $past(regWrData)) == '0));

  p_irq_any_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqAny == (irqSingle | irqUncorr));

  p_irq_unc_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqUncorr == (irqRamUncorr | irqFlashUncorr));

endmodule

bind ecc_evt_report ecc_evt_report_chk #(.REG_AW(REG_AW)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .evtPulse       (evtPulse),
  .enReg          (enReg),
  .stsReg         (stsReg),
  .regWrEn        (regWrEn),
  .regAddr        (regAddr),
  .regWrData      (regWrData),
  .irqSingle      (irqSingle),
  .irqRamUncorr   (irqRamUncorr),
  .irqFlashUncorr (irqFlashUncorr),
  .irqUncorr      (irqUncorr),
  .irqAny         (irqAny)
);

// File: tb/ecc_evt_report_tb.sv
`timescale 1ns/1ps
module ecc_evt_report_tb;

  localparam int ADDR_W = 32;
  localparam int ATTR_W = 8;
  localparam int REG_AW = 3;
  localparam int RD_W   = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              ramCorrPulse, flashCorrPulse, ramUncorrPulse, flashUncorrPulse;
  logic [ADDR_W-1:0] ramAddr, flashAddr;
  logic [ATTR_W-1:0] ramAttr, flashAttr;
  logic              regWrEn;
  logic [REG_AW-1:0] regAddr;
  logic [3:0]        regWrData;
  logic [RD_W-1:0]   regRdData;
  logic              irqSingle, irqRamUncorr, irqFlashUncorr, irqUncorr, irqAny;

  always #2 clk = ~clk;

  ecc_evt_report #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .REG_AW(REG_AW), .RD_W(RD_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .ramCorrPulse(ramCorrPulse), .flashCorrPulse(flashCorrPulse),
    .ramUncorrPulse(ramUncorrPulse), .flashUncorrPulse(flashUncorrPulse),
    .ramAddr(ramAddr), .ramAttr(ramAttr), .flashAddr(flashAddr), .flashAttr(flashAttr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqSingle(irqSingle), .irqRamUncorr(irqRamUncorr), .irqFlashUncorr(irqFlashUncorr),
    .irqUncorr(irqUncorr), .irqAny(irqAny)
  );

  int checks = 0;
  int errors = 0;
  bit modelOn = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [3:0]  mEn, mSts;
  logic [31:0] mAddr;
  logic [7:0]  mAttr;

  always @(posedge clk) begin
    int w;
    w = -1;
    if (!rstN) begin
      mEn = '0; mSts = '0; mAddr = '0; mAttr = '0;
    end else begin
      if      (ramUncorrPulse   && mEn[2]) w = 2;
      else if (flashUncorrPulse && mEn[3]) w = 3;
      else if (ramCorrPulse     && mEn[0]) w = 0;
      else if (flashCorrPulse   && mEn[1]) w = 1;
      if (w >= 0) begin
        mSts = 4'(1 << w);
        if (w == 1 || w == 3) begin mAddr = flashAddr; mAttr = flashAttr; end
        else                  begin mAddr = ramAddr;   mAttr = ramAttr;   end
      end else if (regWrEn && regAddr == 3'd1) begin
        mSts = mSts & ~regWrData;
      end
      if (regWrEn && regAddr == 3'd0) mEn = regWrData;
    end
  end

  function automatic logic [31:0] modelRead(logic [2:0] a);
    case (a)
      3'd0: return {28'd0, mEn};
      3'd1: return {28'd0, mSts};
      3'd2: return mAddr;
      3'd3: return {24'd0, mAttr};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [4:0] modelIrq();
    logic [3:0] p;
    p = mSts & mEn;
    return {|p, p[2] | p[3], p[3], p[2], p[0] | p[1]};
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (modelOn) begin
      check("R9 irq vs model", {27'd0, irqAny, irqUncorr, irqFlashUncorr, irqRamUncorr, irqSingle},
            {27'd0, modelIrq()});
      check("R10 read vs model", regRdData, modelRead(regAddr));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    ramCorrPulse = 0; flashCorrPulse = 0; ramUncorrPulse = 0; flashUncorrPulse = 0;
    regWrEn = 0;
  endtask

  // mask order {flashUnc, ramUnc, flashCor, ramCor}
  task automatic fire(logic [3:0] m, logic [31:0] ra, logic [7:0] rat, logic [31:0] fa, logic [7:0] fat);
    {flashUncorrPulse, ramUncorrPulse, flashCorrPulse, ramCorrPulse} = m;
    ramAddr = ra; ramAttr = rat; flashAddr = fa; flashAttr = fat;
    tick();
    idle();
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    tick();
    idle();
  endtask

  task automatic expReg(logic [2:0] a, logic [31:0] exp, string req);
    regAddr = a;
    @(negedge clk);
    check(req, regRdData, exp);
    tick();
  endtask

  // expected {any, uncorr, flashUnc, ramUnc, single}
  task automatic expIrq(logic [4:0] exp, string req);
    @(negedge clk);
    check(req, {27'd0, irqAny, irqUncorr, irqFlashUncorr, irqRamUncorr, irqSingle}, {27'd0, exp});
    tick();
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; idle();
    regAddr = 0; regWrData = 0;
    ramAddr = 0; ramAttr = 0; flashAddr = 0; flashAttr = 0;
    repeat (2) @(posedge clk);
    for (int a = 0; a < 4; a++) begin
      regAddr = 3'(a);
      @(negedge clk);
      check("R1 reset register", regRdData, 32'd0);
    end
    @(negedge clk);
    check("R1 reset irq", {27'd0, irqAny, irqUncorr, irqFlashUncorr, irqRamUncorr, irqSingle}, 32'd0);
    @(posedge clk); #1;
    rstN = 1;
    modelOn = 1'b1;

    // R2: all kinds disabled
    fire(4'b1111, 32'hAAAA_0001, 8'h5A, 32'hBBBB_0001, 8'hA5);
    expReg(3'd1, 32'd0, "R2 disabled status");
    expReg(3'd2, 32'd0, "R2 disabled address");

    // R10: enable register and reserved bits
    wr(3'd0, 4'hF);
    expReg(3'd0, 32'h0000_000F, "R10 enable readback");

    // R3: single events
    fire(4'b0001, 32'h0000_1000, 8'h11, 32'h0000_9000, 8'h99);
    expReg(3'd1, 32'h1, "R3 ram single flag");
    expReg(3'd2, 32'h0000_1000, "R3 ram address");
    expReg(3'd3, 32'h11, "R3 ram attribute");
    expIrq(5'b10001, "R9 single irq");

    // R5: replacement by a newer event
    fire(4'b1000, 32'h0000_1111, 8'h12, 32'h0000_2000, 8'h22);
    expReg(3'd1, 32'h8, "R5 flash uncorr replaces");
    expReg(3'd2, 32'h0000_2000, "R5 flash address");
    expReg(3'd3, 32'h22, "R5 flash attribute");
    expIrq(5'b11100, "R9 flash uncorr irq");

    // R6: precedence
    fire(4'b1111, 32'h0000_3000, 8'h33, 32'h0000_4000, 8'h44);
    expReg(3'd1, 32'h4, "R6 ram uncorr first");
    expReg(3'd2, 32'h0000_3000, "R6 ram address kept");
    expIrq(5'b11010, "R9 ram uncorr irq");
    fire(4'b1001, 32'h0000_3100, 8'h31, 32'h0000_4100, 8'h41);
    expReg(3'd1, 32'h8, "R6 flash uncorr over ram single");
    expReg(3'd2, 32'h0000_4100, "R6 flash address");
    fire(4'b0011, 32'h0000_3200, 8'h32, 32'h0000_4200, 8'h42);
    expReg(3'd1, 32'h1, "R6 ram single over flash single");
    expReg(3'd3, 32'h32, "R6 ram attribute");

    // R7: write-one-to-clear
    wr(3'd1, 4'h0);
    expReg(3'd1, 32'h1, "R7 write zero keeps flag");
    wr(3'd1, 4'hE);
    expReg(3'd1, 32'h1, "R7 other bits keep flag");
    wr(3'd1, 4'h1);
    expReg(3'd1, 32'h0, "R7 write one clears");
    expIrq(5'b00000, "R7 irq low after clear");

    // R8: event against a same-cycle clear
    fire(4'b0010, 32'h0, 8'h0, 32'h0000_5000, 8'h55);
    regWrEn = 1; regAddr = 3'd1; regWrData = 4'h2;
    {flashUncorrPulse, ramUncorrPulse, flashCorrPulse, ramCorrPulse} = 4'b0100;
    ramAddr = 32'h0000_6000; ramAttr = 8'h66;
    tick(); idle();
    expReg(3'd1, 32'h4, "R8 new event beats clear");
    expReg(3'd2, 32'h0000_6000, "R8 address of new event");
    regWrEn = 1; regAddr = 3'd1; regWrData = 4'h4;
    ramUncorrPulse = 1; ramAddr = 32'h0000_6100; ramAttr = 8'h61;
    tick(); idle();
    expReg(3'd1, 32'h4, "R8 same flag survives clear");

    // R9: disabling the enable drops the irq but not the flag
    wr(3'd0, 4'hB);
    expIrq(5'b00000, "R9 irq gated by enable");
    expReg(3'd1, 32'h4, "R9 flag kept while disabled");
    // R2: disabled kind with fresh address
    fire(4'b0100, 32'h0000_7777, 8'h77, 32'h0, 8'h0);
    expReg(3'd2, 32'h0000_6100, "R2 capture unchanged");
    expReg(3'd1, 32'h4, "R2 status unchanged");

    // R10: capture registers read-only, unmapped read zero
    wr(3'd2, 4'hF);
    expReg(3'd2, 32'h0000_6100, "R10 capture write ignored");
    wr(3'd3, 4'h0);
    expReg(3'd3, 32'h61, "R10 attribute write ignored");
    expReg(3'd5, 32'd0, "R10 unmapped offset");

    // random mix checked against the model every cycle (R4 and all)
    for (int i = 0; i < 600; i++) begin
      {flashUncorrPulse, ramUncorrPulse, flashCorrPulse, ramCorrPulse} = ($urandom % 3 == 0) ? 4'($urandom) : 4'd0;
      ramAddr = $urandom; ramAttr = 8'($urandom);
      flashAddr = $urandom; flashAttr = 8'($urandom);
      regWrEn = ($urandom % 3 == 0);
      regAddr = 3'($urandom % 6);
      regWrData = 4'($urandom);
      tick();
    end
    idle();
    regAddr = 3'd1;
    @(negedge clk);
    checks++;
    if (!$onehot0(regRdData)) begin
      errors++;
      $display("FAIL R4 one flag: actual 0x%0h expected at most one bit", regRdData);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule